// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block is a memory-mapped pulse-width modulator with a single output pin. Software sets a period and a prescale ratio, then feeds duty values into a four-entry sample queue. A period counter advances on each prescaled tick. The pin is driven by comparing that counter with the duty value currently in use. Each queued value can be held for 1, 2, 4 or 8 periods before the next one is taken, so software can stream a waveform without rewriting a compare register exactly on time.

Access is through a plain 32-bit register port: address, write strobe, write data and combinational read data. There are four registers: control, status, sample and period. Status reports the queue fill level and four sticky event flags, which software clears by writing 1 to them. A self-clearing bit in the control register returns the whole block to its reset state.

Top module: `fifo_pwm`

## Requirements
- R1: Registers sit at control 0x00, status 0x04, sample 0x0C and period 0x10. Control reads back its stored fields: enable bit 0, repeat bits 2:1, prescale bits 15:4, two clock-select bits 17:16, mode bits 19:18 and four power-control bits 25:22. Every other control bit, including bit 3, reads 0. The period register reads back its 16 written bits.
- R2: While control bit 0 is 0, pwm_o is 0 whatever the mode, sample and period settings are.
- R3: Control bits 15:4 hold the prescale ratio minus one: the counter advances once every (field+1) clocks.
- R4: One output period lasts (period+2) prescaled ticks. A period register value of 0xFFFF gives the same 0x10000-tick period as 0xFFFE.
- R5: Mode 0 in bits 19:18 drives pwm_o high while the counter is below the sample in use and low after that. Mode 1 gives the inverse. Modes 2 and 3 hold pwm_o low.
- R6: Repeat field values 0, 1, 2 and 3 use each sample for 1, 2, 4 and 8 periods. The next queued sample is taken at a period boundary. If the queue is empty, the last sample stays in use.
- R7: Writes to the sample register fill a 4-entry queue, and status bits 2:0 give the fill level (0 to 4). A write to a full queue is dropped and sets status bit 6.
- R8: The status flags are sticky. Bit 3 sets while the queue is empty, bit 4 sets at each period end, and bit 5 sets when the counter equals the sample in use. Writing 1 to one of bits 6:3 clears that flag, but a new set event in the same cycle takes priority over the clear.
- R9: Writing 1 to control bit 3 empties the queue and returns every register and flag to its reset value within that write cycle.
- R10: Reading the sample register returns the sample in use while enabled, and 0 while disabled.
- R11: After reset, control reads 0, period reads 0xFFFE, sample reads 0 and pwm_o is 0. One clock later, status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pwm_o | output | 1 | Modulated output |

## Verification
A register write takes effect at the clock edge on which it is strobed, and read data follows the address in the same cycle. The bench therefore reads every register half a clock after its last write.

Setting the enable bit loads the first sample at the next edge, and the first period starts from that edge. The bench waits one extra clock after the enabling write, then samples pwm_o on falling edges for exactly one period of (period+2)×(prescale+1) cycles. It counts the high cycles in each such window and compares the count with the value derived from R3 to R6.

The queue, repeat and 0xFFFF cases are checked period by period from that same origin. Status is read only after the write strobe has ended, so the flag-setting edges have already passed.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 12;
  localparam int REP_W   = 2;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_SAMPLE = 8'h0C;
  localparam logic [7:0] OFF_PERIOD = 8'h10;

  localparam int BIT_EN   = 0;
  localparam int REP_LSB  = 1;
  localparam int BIT_SWR  = 3;
  localparam int PRE_LSB  = 4;
  localparam int CKS_LSB  = 16;
  localparam int MODE_LSB = 18;
  localparam int LP_LSB   = 22;

  localparam int ST_EMPTY = 3;
  localparam int ST_ROLL  = 4;
  localparam int ST_CMP   = 5;
  localparam int ST_WERR  = 6;

  localparam logic [CNT_W-1:0] PERIOD_RST = 16'hFFFE;

  typedef enum logic [1:0] {
    MODE_HIGH_FIRST = 2'd0,
    MODE_LOW_FIRST  = 2'd1,
    MODE_OFF_A      = 2'd2,
    MODE_OFF_B      = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic [3:0]       lp;
    out_mode_e        mode;
    logic [1:0]       cks;
    logic [PRE_W-1:0] presc;
    logic [REP_W-1:0] rep;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.en    = w[BIT_EN];
    c.rep   = w[REP_LSB +: REP_W];
    c.presc = w[PRE_LSB +: PRE_W];
    c.cks   = w[CKS_LSB +: 2];
    c.mode  = out_mode_e'(w[MODE_LSB +: 2]);
    c.lp    = w[LP_LSB +: 4];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_EN]             = c.en;
    w[REP_LSB +: REP_W]   = c.rep;
    w[PRE_LSB +: PRE_W]   = c.presc;
    w[CKS_LSB +: 2]       = c.cks;
    w[MODE_LSB +: 2]      = c.mode;
    w[LP_LSB +: 4]        = c.lp;
    return w;
  endfunction
endpackage

// File: rtl/fpwm_fifo.sv
module fpwm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_next(wptr_q);
      if (do_pop)  rptr_q <= ptr_next(rptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (level_q == LVL_W'(DEPTH))); // R7
  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LVL_W'(DEPTH)); // R7
endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase #(
  parameter int PRE_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, pr_eff, last;
  logic             tick;

  // all-ones period folds onto all-ones minus one
  assign pr_eff = (&period_i) ? period_i - 1'b1 : period_i;
  assign last   = pr_eff + 1'b1;
  assign tick   = run_i && (pre_q == presc_i);
  assign wrap_o = tick && (cnt_q >= last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0 && pre_q == '0)); // R4
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && run_i) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/fpwm_seq.sv
module fpwm_seq #(
  parameter int W     = 16,
  parameter int REP_W = 2,
  localparam int RC_W = (1 << REP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic [REP_W-1:0] rep_sel_i,
  input  logic             empty_i,
  input  logic [W-1:0]     head_i,
  output logic             pop_o,
  output logic             run_o,
  output logic [W-1:0]     cur_o
);
  logic [RC_W-1:0] rep_q, rep_lim;
  logic [W-1:0]    cur_q;
  logic            run_q, last_rep, load;

  assign rep_lim  = RC_W'((32'd1 << rep_sel_i) - 32'd1);
  assign last_rep = (rep_q >= rep_lim);
  assign load     = en_i && !clr_i && (!run_q || (wrap_i && last_rep));
  assign pop_o    = load && !empty_i;
  assign run_o    = run_q;
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      rep_q <= '0;
      cur_q <= '0;
    end else if (clr_i) begin
      run_q <= 1'b0;
      rep_q <= '0;
      cur_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      rep_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (load) begin
        rep_q <= '0;
        if (!empty_i) cur_q <= head_i;
      end else if (wrap_i) begin
        rep_q <= rep_q + 1'b1;
      end
    end
  end

  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !clr_i && !wrap_i) |=> $stable(cur_q)); // R6
  AST_POP_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && run_q) |-> wrap_i); // R6
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
  import fpwm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              pwm_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q, cnt, cur, head;
  logic [LVL_W-1:0] level;
  logic             fe_q, roll_q, cmp_q, werr_q;
  logic             sel_ctrl, sel_stat, sel_smp, sel_per, swr, push_req;
  logic             fifo_full, fifo_empty, pop, run, wrap, active;

  assign sel_ctrl = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_stat = we_i && (addr_i == ADDR_W'(OFF_STATUS));
  assign sel_smp  = we_i && (addr_i == ADDR_W'(OFF_SAMPLE));
  assign sel_per  = we_i && (addr_i == ADDR_W'(OFF_PERIOD));
  assign swr      = sel_ctrl && wdata_i[BIT_SWR];
  assign push_req = sel_smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
    end else if (swr) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
    end else begin
      if (sel_ctrl) ctrl_q <= word_to_ctrl(wdata_i);
      if (sel_per)  period_q <= wdata_i[CNT_W-1:0];
    end
  end

  fpwm_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (swr),
    .push_i  (push_req),
    .wdata_i (wdata_i[CNT_W-1:0]),
    .pop_i   (pop),
    .head_o  (head),
    .level_o (level),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  fpwm_seq #(.W(CNT_W), .REP_W(REP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (swr),
    .en_i      (ctrl_q.en),
    .wrap_i    (wrap),
    .rep_sel_i (ctrl_q.rep),
    .empty_i   (fifo_empty),
    .head_i    (head),
    .pop_o     (pop),
    .run_o     (run),
    .cur_o     (cur)
  );

  fpwm_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .presc_i  (ctrl_q.presc),
    .period_i (period_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  // sticky flags: set beats write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fe_q   <= 1'b0;
      roll_q <= 1'b0;
      cmp_q  <= 1'b0;
      werr_q <= 1'b0;
    end else if (swr) begin
      fe_q   <= 1'b0;
      roll_q <= 1'b0;
      cmp_q  <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      fe_q   <= fifo_empty             | (fe_q   & ~(sel_stat & wdata_i[ST_EMPTY]));
      roll_q <= wrap                   | (roll_q & ~(sel_stat & wdata_i[ST_ROLL]));
      cmp_q  <= (run && cnt == cur)    | (cmp_q  & ~(sel_stat & wdata_i[ST_CMP]));
      werr_q <= (push_req & fifo_full) | (werr_q & ~(sel_stat & wdata_i[ST_WERR]));
    end
  end

  assign active = (cnt < cur);

  always_comb begin
    pwm_o = 1'b0;
    if (ctrl_q.en && run) begin
      case (ctrl_q.mode)
        MODE_HIGH_FIRST: pwm_o = active;
        MODE_LOW_FIRST:  pwm_o = !active;
        default:         pwm_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL):   rdata_o = ctrl_to_word(ctrl_q);
      ADDR_W'(OFF_STATUS): begin
        rdata_o[LVL_W-1:0] = level;
        rdata_o[ST_EMPTY]  = fe_q;
        rdata_o[ST_ROLL]   = roll_q;
        rdata_o[ST_CMP]    = cmp_q;
        rdata_o[ST_WERR]   = werr_q;
      end
      ADDR_W'(OFF_SAMPLE): rdata_o[CNT_W-1:0] = ctrl_q.en ? cur : '0;
      ADDR_W'(OFF_PERIOD): rdata_o[CNT_W-1:0] = period_q;
      default:             rdata_o = '0;
    endcase
  end

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> !pwm_o); // R2
  AST_MODE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.mode[1] |-> !pwm_o); // R5
  AST_SWR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> (ctrl_q == '0 && level == '0 && period_q == PERIOD_RST && !werr_q)); // R9
  AST_WERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && fifo_full && !swr) |=> werr_q); // R7
endmodule

// File: tb/fifo_pwm_bench.sv
module fifo_pwm_bench;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMP = 5'h0C, A_PER = 5'h10;

  typedef struct packed {
    logic [11:0] presc;
    logic [15:0] per;
    logic [15:0] smp;
    logic [1:0]  mode;
    logic [31:0] exp_hi;
    logic [31:0] len;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'd0, 16'd6, 16'd3, 2'd0, 32'd3, 32'd8},
    '{12'd0, 16'd6, 16'd3, 2'd1, 32'd5, 32'd8},
    '{12'd2, 16'd3, 16'd2, 2'd0, 32'd6, 32'd15},
    '{12'd0, 16'd2, 16'd9, 2'd0, 32'd4, 32'd4},
    '{12'd0, 16'd4, 16'd0, 2'd0, 32'd0, 32'd6},
    '{12'd1, 16'd4, 16'd4, 2'd2, 32'd0, 32'd12},
    '{12'd0, 16'd6, 16'd0, 2'd1, 32'd8, 32'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pwm;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_pwm #(.ADDR_W(ADDR_W), .DEPTH(4)) u_fifo_pwm (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic measure(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(A_CTRL, v); chk("R11 ctrl", v, 32'h0);
    rd(A_PER, v);  chk("R11 period", v, 32'hFFFE);
    rd(A_SMP, v);  chk("R11 sample", v, 32'h0);
    rd(A_STAT, v); chk("R11 status", v, 32'h08);
    chk("R11 pwm", {31'd0, pwm}, 32'd0);

    // R1 readback of stored control fields, bit 3 excluded
    wr(A_CTRL, 32'h03C7_6346);
    rd(A_CTRL, v); chk("R1 ctrl fields", v, 32'h03C7_6346);
    wr(A_CTRL, 32'hFFFF_FFF6);
    rd(A_CTRL, v); chk("R1 ctrl unused bits", v, 32'h03CF_FFF6);
    wr(A_PER, 32'hABCD_1234);
    rd(A_PER, v);  chk("R1 period", v, 32'h1234);

    // R2 mode 1 but disabled: low for many cycles
    wr(A_CTRL, 32'h8);
    wr(A_PER, 32'd6);
    wr(A_SMP, 32'd3);
    wr(A_CTRL, 32'h0004_0000);
    measure(20, hi); chk("R2 disabled inverted", hi, 0);
    // R10 disabled sample read
    rd(A_SMP, v); chk("R10 disabled read", v, 32'h0);

    // vector table: R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      wr(A_CTRL, 32'h8);
      wr(A_PER, {16'd0, VECS[k].per});
      wr(A_SMP, {16'd0, VECS[k].smp});
      wr(A_CTRL, {12'd0, VECS[k].mode, 2'd0, VECS[k].presc, 4'd1});
      @(negedge clk);
      measure(int'(VECS[k].len), hi);
      chk($sformatf("R3/R4/R5 row %0d highs", k), hi, VECS[k].exp_hi);
      rd(A_SMP, v);
      chk($sformatf("R10 row %0d enabled read", k), v, {16'd0, VECS[k].smp});
    end

    // R8 flags from last row run, then write-one-to-clear while stopped
    rd(A_STAT, v); chk("R8 roll and compare set", v & 32'h30, 32'h30);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h30);
    rd(A_STAT, v); chk("R8 w1c", v & 32'h30, 32'h0);

    // R6 repeat 2x with queue draining, last sample kept
    wr(A_CTRL, 32'h8);
    wr(A_PER, 32'd6);
    wr(A_SMP, 32'd2);
    wr(A_SMP, 32'd5);
    wr(A_CTRL, 32'h3);
    @(negedge clk);
    measure(8, hi); chk("R6 2x p0", hi, 2);
    measure(8, hi); chk("R6 2x p1", hi, 2);
    measure(8, hi); chk("R6 2x p2", hi, 5);
    measure(8, hi); chk("R6 2x p3", hi, 5);
    measure(8, hi); chk("R6 empty keeps last", hi, 5);

    // R6 repeat 4x
    wr(A_CTRL, 32'h8);
    wr(A_PER, 32'd6);
    wr(A_SMP, 32'd1);
    wr(A_SMP, 32'd3);
    wr(A_CTRL, 32'h5);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      measure(8, hi); chk("R6 4x first sample", hi, 1);
    end
    measure(8, hi); chk("R6 4x second sample", hi, 3);

    // R9 soft reset
    wr(A_CTRL, 32'h0004_0051);
    wr(A_SMP, 32'd2);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R9 ctrl cleared", v, 32'h0);
    rd(A_STAT, v); chk("R9 status cleared", v, 32'h0);
    rd(A_PER, v);  chk("R9 period reset", v, 32'hFFFE);
    chk("R9 pwm low", {31'd0, pwm}, 32'd0);
    @(negedge clk);
    rd(A_STAT, v); chk("R8 empty flag sets", v, 32'h08);

    // R7 queue level, overflow drop, error flag
    wr(A_SMP, 32'd1);
    wr(A_SMP, 32'd2);
    wr(A_SMP, 32'd3);
    wr(A_SMP, 32'd4);
    rd(A_STAT, v); chk("R7 level 4", v & 32'h7, 32'd4);
    wr(A_STAT, 32'h78);
    rd(A_STAT, v); chk("R8 all cleared", v, 32'h04);
    wr(A_SMP, 32'd9);
    rd(A_STAT, v); chk("R7 write error", v, 32'h44);
    wr(A_PER, 32'd6);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    for (int p = 1; p <= 4; p++) begin
      measure(8, hi); chk("R7 queued order", hi, p);
    end
    measure(8, hi); chk("R7 dropped write absent", hi, 4);

    // R4 all-ones period acts as 0xFFFE
    wr(A_CTRL, 32'h8);
    wr(A_PER, 32'hFFFF);
    wr(A_SMP, 32'h8000);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    measure(65536, hi); chk("R4 0xFFFF highs", hi, 32'h8000);
    chk("R4 0xFFFF next period start", {31'd0, pwm}, 32'd1);

    done = 1;
    summary();
    $finish;
  end
endmodule